// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block holds recently used virtual-to-physical page mappings for a system with 4 KB pages. A requester presents an address-space tag and a virtual address. The block splits the address into a page number and an in-page offset. The low bits of the page number select a set, and the tag, address-space tag and valid bit of every way in that set are compared at once. The result is registered: one cycle after a request is accepted, the block reports a hit with the physical address and the page's permission flags, or it reports a miss.

On a miss the block raises a walk request toward an external page-table walker, holds its request-ready signal low, and waits for one refill beat. It places the refill in an empty way if the set has one. Otherwise it evicts the way that was used least recently. Entries are keyed by the pair of address-space tag and page number, so mappings from several address spaces can sit side by side. Software-driven maintenance can clear everything at once or remove a single page. A refill for a page that was invalidated, or flushed, while its walk was in flight is thrown away.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, `rsp_paddr` equals the stored frame number placed above the untouched low 12 bits of the request's virtual address.
- R2: `rsp_valid` is high in exactly the cycle after an accepted request (`req_valid` and `req_ready` both high). The answer reflects the contents before that cycle, even when a flush or an invalidate is applied in the same cycle.
- R3: The set index is bits 3:0 of the virtual page number (16 sets by default) and each set holds 4 ways. Replacement in one set never disturbs entries of another set.
- R4: A hit returns six permission flags on `rsp_perm`: bit 0 present, bit 1 writable, bit 2 user, bit 3 dirty, bit 4 accessed, bit 5 no-execute. A miss reports `rsp_paddr` and `rsp_perm` as zero.
- R5: After a miss, `walk_valid` is high with the request's address-space tag and page number, and `req_ready` is low. The cycle in which `fill_valid` is seen ends the wait. `req_ready` is high again in the next cycle, and the page then hits.
- R6: A hit or a refill makes its way the most recently used in its set. A refill into a full set evicts the least recently used way.
- R7: A lookup hits only when both the address-space tag and the page number match. The same page number under two tags can be held at once.
- R8: A `flush` pulse invalidates every entry, so every later lookup misses until refilled.
- R9: An `inv_valid` pulse removes only the entry matching both `inv_asid` and `inv_vpn`. Entries with another page or another tag keep hitting.
- R10: A way freed by an invalidate is chosen for the next refill of its set ahead of the least recently used valid way.
- R11: If an invalidate of the outstanding page, or a flush, happens while its walk is pending (including the cycle of the refill), the refill is discarded and the page still misses afterwards. An invalidate of a different page does not discard it.
- R12: `fill_valid` while no miss is outstanding changes nothing: no entry is written and the ready, walk and response outputs are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request (low while a walk is pending) |
| req_asid | input | ASID_W | Address-space tag of the request |
| req_vaddr | input | VA_W | Virtual address of the request |
| rsp_valid | output | 1 | Lookup result valid this cycle |
| rsp_hit | output | 1 | Result was a hit |
| rsp_paddr | output | PA_W | Physical address on a hit, zero on a miss |
| rsp_perm | output | 6 | Permission flags on a hit, zero on a miss |
| walk_valid | output | 1 | A walk is outstanding |
| walk_asid | output | ASID_W | Address-space tag to walk |
| walk_vpn | output | VA_W-12 | Page number to walk |
| fill_valid | input | 1 | Refill beat from the walker |
| fill_pfn | input | PA_W-12 | Frame number of the refill |
| fill_perm | input | 6 | Permission flags of the refill |
| flush | input | 1 | Invalidate all entries |
| inv_valid | input | 1 | Invalidate one page |
| inv_asid | input | ASID_W | Address-space tag of the page to invalidate |
| inv_vpn | input | VA_W-12 | Page number to invalidate |

## Verification
Two pairs of functions can fall in the same clock edge, and the bench creates both on purpose. In the first pair, an accepted lookup and an invalidate (or a flush) of the same page are driven in the same cycle. The bench expects that response to still be a hit and the very next lookup to miss. In the second pair, a refill beat and an invalidate of the outstanding page arrive together. The bench judges this by issuing a fresh lookup of that page and expecting a miss with a new walk request. A control case, in which an unrelated page is invalidated during the walk, must keep its refill.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // In-page offset width for 4 KB pages.
    localparam int OFF_W = 12;

    // Page permission flags, bit 0 = present.
    typedef struct packed {
        logic no_exec;
        logic accessed;
        logic dirty;
        logic user;
        logic writable;
        logic present;
    } perm_t;

    localparam int PERM_W = $bits(perm_t);

    // Index of the lowest set bit; 0 when none is set.
    function automatic int unsigned lowest_one(input logic [63:0] vec);
        int unsigned idx;
        idx = 0;
        for (int i = 63; i >= 0; i--) begin
            if (vec[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int WAYS   = 4,
    parameter int ASID_W = 8,
    parameter int TAG_W  = 32
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][ASID_W-1:0] way_asid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [ASID_W-1:0]           key_asid,
    input  logic [TAG_W-1:0]            key_tag,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        hit_any
);

    // One comparator per way, all in parallel.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_asid[w] == key_asid) && (way_tag[w] == key_tag);
    end

    assign hit_any = |hit_vec;

endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [IDX_W-1:0] q_set,
    output logic [WAYS-1:0]  q_oldest
);

    localparam logic [WAY_W-1:0] OLDEST_AGE = WAY_W'(WAYS - 1);

    logic [WAYS-1:0] oldest_of [SETS];

    // Each set keeps a permutation of ages: 0 = most recent, WAYS-1 = victim.
    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [WAYS-1:0][WAY_W-1:0] age_q;
        logic [WAYS-1:0]            old_vec;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < WAYS; w++) age_q[w] <= WAY_W'(w);
            end else if (touch_en && (touch_set == IDX_W'(s))) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way)
                        age_q[w] <= '0;
                    else if (age_q[w] < age_q[touch_way])
                        age_q[w] <= age_q[w] + 1'b1;
                end
            end
        end

        always_comb begin
            for (int w = 0; w < WAYS; w++) old_vec[w] = (age_q[w] == OLDEST_AGE);
        end

        assign oldest_of[s] = old_vec;

        // R6: ages stay a permutation, so exactly one way is the oldest.
        a_r6_single_oldest: assert property (@(posedge clk) disable iff (rst)
            $countones(old_vec) == 1);
    end

    assign q_oldest = oldest_of[q_set];

endmodule

// File: rtl/xlat_store.sv
module xlat_store #(
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int ASID_W = 8,
    parameter int TAG_W  = 32,
    parameter int PFN_W  = 28,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    // lookup / refill read port
    input  logic [IDX_W-1:0]             a_set,
    output logic [WAYS-1:0]              a_valid,
    output logic [WAYS-1:0][ASID_W-1:0]  a_asid,
    output logic [WAYS-1:0][TAG_W-1:0]   a_tag,
    output logic [WAYS-1:0][PFN_W-1:0]   a_pfn,
    output xlat_pkg::perm_t [WAYS-1:0]   a_perm,
    // maintenance read port
    input  logic [IDX_W-1:0]             b_set,
    output logic [WAYS-1:0]              b_valid,
    output logic [WAYS-1:0][ASID_W-1:0]  b_asid,
    output logic [WAYS-1:0][TAG_W-1:0]   b_tag,
    // maintenance actions
    input  logic                         flush,
    input  logic                         inv_en,
    input  logic [WAYS-1:0]              inv_mask,
    // refill write
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [ASID_W-1:0]            wr_asid,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [PFN_W-1:0]             wr_pfn,
    input  xlat_pkg::perm_t              wr_perm
);

    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [ASID_W-1:0]         asid_q [SETS][WAYS];
    logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
    logic [PFN_W-1:0]          pfn_q  [SETS][WAYS];
    xlat_pkg::perm_t           perm_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            if (inv_en) valid_q[b_set] <= valid_q[b_set] & ~inv_mask;
            if (wr_en)  valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            asid_q[wr_set][wr_way] <= wr_asid;
            tag_q[wr_set][wr_way]  <= wr_tag;
            pfn_q[wr_set][wr_way]  <= wr_pfn;
            perm_q[wr_set][wr_way] <= wr_perm;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            a_valid[w] = valid_q[a_set][w];
            a_asid[w]  = asid_q[a_set][w];
            a_tag[w]   = tag_q[a_set][w];
            a_pfn[w]   = pfn_q[a_set][w];
            a_perm[w]  = perm_q[a_set][w];
            b_valid[w] = valid_q[b_set][w];
            b_asid[w]  = asid_q[b_set][w];
            b_tag[w]   = tag_q[b_set][w];
        end
    end

    // R8: after a flush cycle no entry is valid.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    // R9: the invalidated ways are cleared unless a refill lands in that cycle.
    a_r9_inval_clears: assert property (@(posedge clk) disable iff (rst)
        (inv_en && !wr_en) |=> ((valid_q[$past(b_set)] & $past(inv_mask)) == '0));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PA_W   = 40,
    parameter int ASID_W = 8,
    parameter int SETS   = 16,
    parameter int WAYS   = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ASID_W-1:0]      req_asid,
    input  logic [VA_W-1:0]        req_vaddr,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [PA_W-1:0]        rsp_paddr,
    output logic [PERM_W-1:0]      rsp_perm,
    output logic                   walk_valid,
    output logic [ASID_W-1:0]      walk_asid,
    output logic [VA_W-OFF_W-1:0]  walk_vpn,
    input  logic                   fill_valid,
    input  logic [PA_W-OFF_W-1:0]  fill_pfn,
    input  logic [PERM_W-1:0]      fill_perm,
    input  logic                   flush,
    input  logic                   inv_valid,
    input  logic [ASID_W-1:0]      inv_asid,
    input  logic [VA_W-OFF_W-1:0]  inv_vpn
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    // ---------------- request split ----------------
    logic [VPN_W-1:0] req_vpn;
    logic [IDX_W-1:0] req_set;
    logic [TAG_W-1:0] req_tag;
    logic             req_fire;

    assign req_vpn  = req_vaddr[VA_W-1:OFF_W];
    assign req_set  = req_vpn[IDX_W-1:0];
    assign req_tag  = req_vpn[VPN_W-1:IDX_W];
    assign req_fire = req_valid && req_ready;

    // ---------------- pending miss state ----------------
    logic              pend_q;
    logic              drop_q;
    logic [ASID_W-1:0] pend_asid_q;
    logic [VPN_W-1:0]  pend_vpn_q;
    logic [IDX_W-1:0]  pend_set;
    logic [TAG_W-1:0]  pend_tag;

    assign pend_set = pend_vpn_q[IDX_W-1:0];
    assign pend_tag = pend_vpn_q[VPN_W-1:IDX_W];

    // ---------------- storage ----------------
    logic [IDX_W-1:0]             a_set;
    logic [WAYS-1:0]              a_valid;
    logic [WAYS-1:0][ASID_W-1:0]  a_asid;
    logic [WAYS-1:0][TAG_W-1:0]   a_tag;
    logic [WAYS-1:0][PFN_W-1:0]   a_pfn;
    perm_t [WAYS-1:0]             a_perm;
    logic [IDX_W-1:0]             b_set;
    logic [WAYS-1:0]              b_valid;
    logic [WAYS-1:0][ASID_W-1:0]  b_asid;
    logic [WAYS-1:0][TAG_W-1:0]   b_tag;
    logic                         wr_en;
    logic [WAY_W-1:0]             victim;

    // While a walk is pending no request is accepted, so the read port
    // is lent to refill victim selection.
    assign a_set = pend_q ? pend_set : req_set;
    assign b_set = inv_vpn[IDX_W-1:0];

    logic [WAYS-1:0] a_hit_vec;
    logic            a_hit;
    logic [WAY_W-1:0] a_way;
    logic [WAYS-1:0] b_hit_vec;
    logic            b_hit;

    xlat_match #(.WAYS(WAYS), .ASID_W(ASID_W), .TAG_W(TAG_W)) u_match_lookup (
        .way_valid (a_valid),
        .way_asid  (a_asid),
        .way_tag   (a_tag),
        .key_asid  (req_asid),
        .key_tag   (req_tag),
        .hit_vec   (a_hit_vec),
        .hit_any   (a_hit)
    );

    xlat_match #(.WAYS(WAYS), .ASID_W(ASID_W), .TAG_W(TAG_W)) u_match_inval (
        .way_valid (b_valid),
        .way_asid  (b_asid),
        .way_tag   (b_tag),
        .key_asid  (inv_asid),
        .key_tag   (inv_vpn[VPN_W-1:IDX_W]),
        .hit_vec   (b_hit_vec),
        .hit_any   (b_hit)
    );

    assign a_way = WAY_W'(lowest_one(64'(a_hit_vec)));

    // ---------------- maintenance vs. pending walk ----------------
    logic inv_hits_pend;
    logic inv_hits_req;
    logic fill_take;

    assign inv_hits_pend = inv_valid && pend_q && (inv_asid == pend_asid_q) && (inv_vpn == pend_vpn_q);
    assign inv_hits_req  = inv_valid && (inv_asid == req_asid) && (inv_vpn == req_vpn);
    assign fill_take     = pend_q && fill_valid;
    assign wr_en         = fill_take && !drop_q && !inv_hits_pend && !flush;

    // ---------------- replacement ----------------
    logic [WAYS-1:0] q_oldest;
    logic            touch_en;
    logic [IDX_W-1:0] touch_set;
    logic [WAY_W-1:0] touch_way;

    assign victim = (~a_valid != '0) ? WAY_W'(lowest_one(64'(~a_valid)))
                                     : WAY_W'(lowest_one(64'(q_oldest)));

    assign touch_en  = (req_fire && a_hit) || wr_en;
    assign touch_set = wr_en ? pend_set : req_set;
    assign touch_way = wr_en ? victim : a_way;

    xlat_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_set (touch_set),
        .touch_way (touch_way),
        .q_set     (a_set),
        .q_oldest  (q_oldest)
    );

    xlat_store #(
        .SETS(SETS), .WAYS(WAYS), .ASID_W(ASID_W), .TAG_W(TAG_W), .PFN_W(PFN_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .a_set    (a_set),
        .a_valid  (a_valid),
        .a_asid   (a_asid),
        .a_tag    (a_tag),
        .a_pfn    (a_pfn),
        .a_perm   (a_perm),
        .b_set    (b_set),
        .b_valid  (b_valid),
        .b_asid   (b_asid),
        .b_tag    (b_tag),
        .flush    (flush),
        .inv_en   (inv_valid && b_hit),
        .inv_mask (b_hit_vec),
        .wr_en    (wr_en),
        .wr_set   (pend_set),
        .wr_way   (victim),
        .wr_asid  (pend_asid_q),
        .wr_tag   (pend_tag),
        .wr_pfn   (fill_pfn),
        .wr_perm  (perm_t'(fill_perm))
    );

    // ---------------- pending miss control ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            drop_q      <= 1'b0;
            pend_asid_q <= '0;
            pend_vpn_q  <= '0;
        end else if (req_fire && !a_hit) begin
            pend_q      <= 1'b1;
            drop_q      <= flush || inv_hits_req;
            pend_asid_q <= req_asid;
            pend_vpn_q  <= req_vpn;
        end else if (fill_take) begin
            pend_q <= 1'b0;
            drop_q <= 1'b0;
        end else if (pend_q && (flush || inv_hits_pend)) begin
            drop_q <= 1'b1;
        end
    end

    // ---------------- registered response ----------------
    logic             rsp_valid_q;
    logic             rsp_hit_q;
    logic [PFN_W-1:0] rsp_pfn_q;
    perm_t            rsp_perm_q;
    logic [OFF_W-1:0] rsp_off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_pfn_q   <= '0;
            rsp_perm_q  <= '0;
            rsp_off_q   <= '0;
        end else begin
            rsp_valid_q <= req_fire;
            if (req_fire) begin
                rsp_hit_q  <= a_hit;
                rsp_pfn_q  <= a_hit ? a_pfn[a_way] : '0;
                rsp_perm_q <= a_hit ? a_perm[a_way] : '0;
                rsp_off_q  <= a_hit ? req_vaddr[OFF_W-1:0] : '0;
            end
        end
    end

    assign req_ready  = !pend_q;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_hit    = rsp_hit_q;
    assign rsp_paddr  = {rsp_pfn_q, rsp_off_q};
    assign rsp_perm   = rsp_perm_q;
    assign walk_valid = pend_q;
    assign walk_asid  = pend_asid_q;
    assign walk_vpn   = pend_vpn_q;

    // ---------------- assertions ----------------
    // R2: an accepted request is answered in the next cycle, and only then.
    a_r2_answer_next: assert property (@(posedge clk) disable iff (rst)
        req_fire |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_fire |=> !rsp_valid);

    // R1: the in-page offset is returned untouched.
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    // R5: a miss answer comes with an open walk and a closed request port.
    a_r5_miss_walks: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (walk_valid && !req_ready && walk_vpn == $past(req_vpn)));

    // R7: a key never matches two ways of a set.
    a_r7_unique_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(a_hit_vec));

    // R12: a refill beat with no walk pending leaves the request port open.
    a_r12_stray_fill: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !walk_valid && !req_fire) |=> (req_ready && !walk_valid));

endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;

    localparam int VA_W   = 48;
    localparam int PA_W   = 40;
    localparam int ASID_W = 8;
    localparam int VPN_W  = VA_W - 12;
    localparam int PFN_W  = PA_W - 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ASID_W-1:0] req_asid = '0;
    logic [VA_W-1:0]   req_vaddr = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [PA_W-1:0]   rsp_paddr;
    logic [5:0]        rsp_perm;
    logic              walk_valid;
    logic [ASID_W-1:0] walk_asid;
    logic [VPN_W-1:0]  walk_vpn;
    logic              fill_valid = 1'b0;
    logic [PFN_W-1:0]  fill_pfn = '0;
    logic [5:0]        fill_perm = '0;
    logic              flush = 1'b0;
    logic              inv_valid = 1'b0;
    logic [ASID_W-1:0] inv_asid = '0;
    logic [VPN_W-1:0]  inv_vpn = '0;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    xlat_cache u_xlat_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_asid(req_asid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
        .walk_valid(walk_valid), .walk_asid(walk_asid), .walk_vpn(walk_vpn),
        .fill_valid(fill_valid), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .flush(flush), .inv_valid(inv_valid), .inv_asid(inv_asid), .inv_vpn(inv_vpn)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic lookup(input logic [7:0] asid, input logic [35:0] vpn, input logic [11:0] off);
        req_valid = 1'b1; req_asid = asid; req_vaddr = {vpn, off};
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic [27:0] pfn, input logic [5:0] perm);
        fill_valid = 1'b1; fill_pfn = pfn; fill_perm = perm;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic inval(input logic [7:0] asid, input logic [35:0] vpn);
        inv_valid = 1'b1; inv_asid = asid; inv_vpn = vpn;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input logic [27:0] pfn, input logic [5:0] perm,
                              input logic [11:0] off);
        chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " rsp_hit"},   64'(rsp_hit),   64'd1);
        chk({tag, " paddr"},     64'(rsp_paddr), 64'({pfn, off}));
        chk({tag, " perm"},      64'(rsp_perm),  64'(perm));
    endtask

    task automatic expect_miss(input string tag, input logic [7:0] asid, input logic [35:0] vpn);
        chk({tag, " rsp_valid"},  64'(rsp_valid),  64'd1);
        chk({tag, " rsp_hit"},    64'(rsp_hit),    64'd0);
        chk({tag, " miss paddr"}, 64'(rsp_paddr),  64'd0);
        chk({tag, " walk_valid"}, 64'(walk_valid), 64'd1);
        chk({tag, " walk_asid"},  64'(walk_asid),  64'(asid));
        chk({tag, " walk_vpn"},   64'(walk_vpn),   64'(vpn));
        chk({tag, " ready low"},  64'(req_ready),  64'd0);
    endtask

    task automatic install(input string tag, input logic [7:0] asid, input logic [35:0] vpn,
                           input logic [27:0] pfn, input logic [5:0] perm);
        lookup(asid, vpn, 12'h0);
        expect_miss(tag, asid, vpn);
        fill(pfn, perm);
        chk({tag, " ready back"}, 64'(req_ready), 64'd1);
        chk({tag, " walk done"},  64'(walk_valid), 64'd0);
    endtask

    task automatic t_reset();
        chk("R2 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R5 reset ready",     64'(req_ready), 64'd1);
        chk("R5 reset walk",      64'(walk_valid), 64'd0);
    endtask

    task automatic t_basic();
        install("R5 first miss", 8'd1, 36'h10, 28'h1234, 6'b000011);
        lookup(8'd1, 36'h10, 12'hABC);
        expect_hit("R1 offset abc", 28'h1234, 6'b000011, 12'hABC);
        chk("R2 one-cycle pulse", 64'(rsp_valid), 64'd1);
        @(negedge clk);
        chk("R2 pulse ends", 64'(rsp_valid), 64'd0);
        lookup(8'd1, 36'h10, 12'hFFF);
        expect_hit("R1 offset fff", 28'h1234, 6'b000011, 12'hFFF);
        install("R5 second page", 8'd1, 36'h20, 28'hBEEF, 6'b101101);
        lookup(8'd1, 36'h20, 12'h001);
        expect_hit("R4 perm 101101", 28'hBEEF, 6'b101101, 12'h001);
    endtask

    task automatic t_asid();
        install("R7 other tag miss", 8'd2, 36'h10, 28'h2222, 6'b000111);
        lookup(8'd1, 36'h10, 12'h001);
        expect_hit("R7 tag1 kept", 28'h1234, 6'b000011, 12'h001);
        lookup(8'd2, 36'h10, 12'h002);
        expect_hit("R7 tag2 hit", 28'h2222, 6'b000111, 12'h002);
    endtask

    task automatic t_lru();
        install("R6 fill a", 8'd3, 36'h05, 28'h505, 6'h03);
        install("R6 fill b", 8'd3, 36'h15, 28'h515, 6'h03);
        install("R6 fill c", 8'd3, 36'h25, 28'h525, 6'h03);
        install("R6 fill d", 8'd3, 36'h35, 28'h535, 6'h03);
        lookup(8'd3, 36'h05, 12'h010);
        expect_hit("R6 touch a", 28'h505, 6'h03, 12'h010);
        install("R6 fill e", 8'd3, 36'h45, 28'h545, 6'h03);
        lookup(8'd3, 36'h05, 12'h0); expect_hit("R6 a kept", 28'h505, 6'h03, 12'h0);
        lookup(8'd3, 36'h25, 12'h0); expect_hit("R6 c kept", 28'h525, 6'h03, 12'h0);
        lookup(8'd3, 36'h35, 12'h0); expect_hit("R6 d kept", 28'h535, 6'h03, 12'h0);
        lookup(8'd3, 36'h45, 12'h0); expect_hit("R6 e hit",  28'h545, 6'h03, 12'h0);
        lookup(8'd3, 36'h15, 12'h0); expect_miss("R6 b evicted", 8'd3, 36'h15);
        fill(28'h515, 6'h03);
        lookup(8'd1, 36'h10, 12'h0); expect_hit("R3 set0 untouched", 28'h1234, 6'b000011, 12'h0);
        lookup(8'd1, 36'h20, 12'h0); expect_hit("R3 set0 second", 28'hBEEF, 6'b101101, 12'h0);
    endtask

    task automatic t_flush();
        pulse_flush();
        chk("R8 ready after flush", 64'(req_ready), 64'd1);
        lookup(8'd1, 36'h10, 12'h0); expect_miss("R8 tag1 gone", 8'd1, 36'h10);
        fill(28'h1234, 6'b000011);
        lookup(8'd3, 36'h35, 12'h0); expect_miss("R8 set5 gone", 8'd3, 36'h35);
        fill(28'h535, 6'h03);
    endtask

    task automatic t_inval();
        install("R10 fill a", 8'd4, 36'h09, 28'h909, 6'h01);
        install("R10 fill b", 8'd4, 36'h19, 28'h919, 6'h01);
        install("R10 fill c", 8'd4, 36'h29, 28'h929, 6'h01);
        install("R10 fill d", 8'd4, 36'h39, 28'h939, 6'h01);
        inval(8'd5, 36'h29);
        inval(8'd4, 36'h39);
        install("R10 refill", 8'd4, 36'h49, 28'h949, 6'h01);
        lookup(8'd4, 36'h09, 12'h0); expect_hit("R10 oldest kept", 28'h909, 6'h01, 12'h0);
        lookup(8'd4, 36'h19, 12'h0); expect_hit("R9 neighbour kept", 28'h919, 6'h01, 12'h0);
        lookup(8'd4, 36'h29, 12'h0); expect_hit("R9 other tag no effect", 28'h929, 6'h01, 12'h0);
        lookup(8'd4, 36'h49, 12'h0); expect_hit("R10 new page", 28'h949, 6'h01, 12'h0);
        lookup(8'd4, 36'h39, 12'h0); expect_miss("R9 removed page", 8'd4, 36'h39);
        fill(28'h939, 6'h01);
    endtask

    task automatic t_discard();
        lookup(8'd6, 36'h0A, 12'h0); expect_miss("R11 a miss", 8'd6, 36'h0A);
        inval(8'd6, 36'h0A);
        chk("R11 walk still open", 64'(walk_valid), 64'd1);
        fill(28'hAAA, 6'h03);
        chk("R11 ready after drop", 64'(req_ready), 64'd1);
        lookup(8'd6, 36'h0A, 12'h0); expect_miss("R11 dropped refill", 8'd6, 36'h0A);
        fill(28'hAAA, 6'h03);
        lookup(8'd6, 36'h0A, 12'h0); expect_hit("R11 normal refill", 28'hAAA, 6'h03, 12'h0);
        // invalidate and refill in the same cycle
        lookup(8'd6, 36'h1A, 12'h0); expect_miss("R11 b miss", 8'd6, 36'h1A);
        inv_valid = 1'b1; inv_asid = 8'd6; inv_vpn = 36'h1A;
        fill(28'h1A1, 6'h03);
        inv_valid = 1'b0;
        lookup(8'd6, 36'h1A, 12'h0); expect_miss("R11 same-cycle drop", 8'd6, 36'h1A);
        fill(28'h1A1, 6'h03);
        // flush during walk
        lookup(8'd6, 36'h2A, 12'h0); expect_miss("R11 c miss", 8'd6, 36'h2A);
        pulse_flush();
        fill(28'h2A2, 6'h03);
        lookup(8'd6, 36'h2A, 12'h0); expect_miss("R11 flush drop", 8'd6, 36'h2A);
        fill(28'h2A2, 6'h03);
        // unrelated invalidate keeps the refill
        lookup(8'd6, 36'h3A, 12'h0); expect_miss("R11 d miss", 8'd6, 36'h3A);
        inval(8'd6, 36'h4A);
        fill(28'h3A3, 6'h03);
        lookup(8'd6, 36'h3A, 12'h0); expect_hit("R11 unrelated kept", 28'h3A3, 6'h03, 12'h0);
    endtask

    task automatic t_stray();
        fill(28'hDEAD, 6'h3F);
        chk("R12 ready", 64'(req_ready), 64'd1);
        chk("R12 no walk", 64'(walk_valid), 64'd0);
        chk("R12 no response", 64'(rsp_valid), 64'd0);
        lookup(8'd6, 36'h3A, 12'h0); expect_hit("R12 entry unchanged", 28'h3A3, 6'h03, 12'h0);
        lookup(8'd7, 36'h0B, 12'h0); expect_miss("R12 nothing written", 8'd7, 36'h0B);
        fill(28'hB0B, 6'h05);
    endtask

    task automatic t_concurrent();
        req_valid = 1'b1; req_asid = 8'd7; req_vaddr = {36'h0B, 12'h005};
        inv_valid = 1'b1; inv_asid = 8'd7; inv_vpn = 36'h0B;
        @(negedge clk);
        req_valid = 1'b0; inv_valid = 1'b0;
        expect_hit("R2 lookup before inval", 28'hB0B, 6'h05, 12'h005);
        lookup(8'd7, 36'h0B, 12'h0); expect_miss("R9 gone after same-cycle inval", 8'd7, 36'h0B);
        fill(28'hB0B, 6'h05);
        req_valid = 1'b1; req_asid = 8'd6; req_vaddr = {36'h3A, 12'h007};
        flush = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; flush = 1'b0;
        expect_hit("R2 lookup before flush", 28'h3A3, 6'h03, 12'h007);
        lookup(8'd6, 36'h3A, 12'h0); expect_miss("R8 gone after same-cycle flush", 8'd6, 36'h3A);
        fill(28'h3A3, 6'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_asid();
        t_lru();
        t_flush();
        t_inval();
        t_discard();
        t_stray();
        t_concurrent();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule